// File: doc/BRIEF.md
# Video Field Capture Controller

This block is the glue between an 8-bit video decoder and a sequential frame buffer. It runs on the buffer's write clock, which is the decoder pixel clock halved so that only luma bytes land in the buffer. A host arms a capture through a 3-bit command on general-purpose pins. The controller then waits for a falling edge of vertical sync that arrives during the odd field. After that edge it drives the buffer's active-low write enable for every pixel that the blanking, active-video and field-ID qualifiers allow.

The controller counts the pixels it writes. On the last pixel of the configured image size (150 × 300 = 45,000 by default) it clears the count and stops writing. It also pulls an active-low interrupt to the host for a fixed number of cycles. The same command pins pulse the buffer's write-pointer and read-pointer resets. A small combinational decode turns the host's chip select, output enable and read strobe into the buffer's read-side enables.

The command pins pass through a two-flop synchronizer. A command acts once, on the cycle its synchronized value first equals a defined code. States: `CAP_IDLE` (after reset, no writes), `CAP_ARMED` (waiting for a start edge), `CAP_ACTIVE` (writing qualified pixels), `CAP_DONE` (image complete, no writes). Transitions: *arm* from IDLE, ACTIVE or DONE to ARMED; *start* from ARMED to ACTIVE on a vertical-sync fall with field ID 0; *complete* from ACTIVE to DONE on the last pixel.

Top module: `vfc_capture_ctrl`

## Requirements
- R1: In the armed state, capture starts only on a clock where vertical sync was high on the previous edge and is low now, with field ID 0 at that moment. A rising edge does not start capture, and neither does a falling edge with field ID 1.
- R2: During capture, write enable is low in the same cycle only when vertical blanking is low and active video is high.
- R3: During capture, field ID 1 forces write enable high whatever the other qualifiers are.
- R4: Write enable stays high in the idle, armed and done states for every qualifier combination.
- R5: When the PIXEL_TARGET-th pixel is written, the counter clears and the state becomes done. The interrupt output goes low from the next clock edge and stays low for IRQ_CYCLES (default 4) cycles.
- R6: Buffer output enable is low exactly when host chip select and host output enable are both low. Buffer read enable is low exactly when host read strobe is low as well.
- R7: Command 3'b001 drives the write-pointer reset low for RST_CYCLES (default 2) cycles. The pulse starts at the third rising edge after the command pins change.
- R8: Command 3'b010 drives the read-pointer reset low for RST_CYCLES cycles, with the same timing as R7.
- R9: Any command other than 3'b001, 3'b010 or 3'b100 pulses nothing and changes no state. Holding a defined command for many cycles acts only once.
- R10: Command 3'b100 arms a capture from the idle or done state. The state becomes armed at the third rising edge after the pins change, and the pixel count starts again from zero.
- R11: Command 3'b100 given during capture abandons it. The count clears, and the next capture needs a new start edge and a full PIXEL_TARGET pixels before the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Buffer write clock (halved pixel clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_vsync | input | 1 | Decoder vertical sync |
| vid_vblank | input | 1 | Decoder vertical blanking, high while blanked |
| vid_active | input | 1 | Decoder active-video qualifier |
| vid_field | input | 1 | Decoder field ID, 0 for odd field |
| host_cmd | input | 3 | Asynchronous command from host GPIO |
| host_cs_n | input | 1 | Host chip select, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| buf_we_n | output | 1 | Buffer write enable, active low |
| buf_wrst_n | output | 1 | Buffer write-pointer reset, active low |
| buf_rrst_n | output | 1 | Buffer read-pointer reset, active low |
| buf_oe_n | output | 1 | Buffer output enable, active low |
| buf_re_n | output | 1 | Buffer read enable, active low |
| host_irq_n | output | 1 | Capture-complete interrupt, active low |

## Verification
The bench uses a six-pixel image. It sweeps all eight qualifier combinations in every state, so a design that ignored field ID or let writes through before arming or after completion would show a low write enable where high is expected. It counts the exact pixel that raises the interrupt and the length of the low pulse; an off-by-one counter fires a pixel early or late. It holds each command for eight cycles and walks all eight codes. This catches a decoder that repeats a pulse, reacts to undefined codes or gets the synchronizer depth wrong. An arm given in the middle of a capture must restart the count, so a counter that is not cleared raises the interrupt too soon.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_ARMED,
        CAP_ACTIVE,
        CAP_DONE
    } cap_state_t;

    localparam int CMD_W = 3;
    localparam logic [CMD_W-1:0] CMD_WRST = 3'b001;
    localparam logic [CMD_W-1:0] CMD_RRST = 3'b010;
    localparam logic [CMD_W-1:0] CMD_ARM  = 3'b100;

endpackage

// File: rtl/vfc_cmd_sync.sv
module vfc_cmd_sync
    import vfc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd_async,
    output logic             wrst_evt,
    output logic             rrst_evt,
    output logic             arm_evt
);
    logic [CMD_W-1:0] stage_q [STAGES];
    logic [CMD_W-1:0] prev_q;
    logic [CMD_W-1:0] cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= cmd_async;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign cur      = stage_q[STAGES-1];
    assign wrst_evt = (cur == CMD_WRST) && (prev_q != CMD_WRST);
    assign rrst_evt = (cur == CMD_RRST) && (prev_q != CMD_RRST);
    assign arm_evt  = (cur == CMD_ARM)  && (prev_q != CMD_ARM);
endmodule

// File: rtl/vfc_pulse.sv
module vfc_pulse #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse_n
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              left_q <= '0;
        else if (trig)           left_q <= CW'(LEN);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign pulse_n = (left_q == '0);
endmodule

// File: rtl/vfc_capture_fsm.sv
module vfc_capture_fsm
    import vfc_pkg::*;
#(
    parameter int PIXEL_TARGET = 45000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_evt,
    input  logic vsync,
    input  logic vblank,
    input  logic active,
    input  logic field,
    output logic we_n,
    output logic done_evt
);
    localparam int CNT_W = $clog2(PIXEL_TARGET + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PIXEL_TARGET - 1);

    cap_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic vs_q;
    logic pix_ok, vs_fall, take;

    assign pix_ok  = !vblank && active && !field;
    assign vs_fall = vs_q && !vsync;
    assign take    = (state_q == CAP_ACTIVE) && !arm_evt && pix_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            vs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            vs_q    <= vsync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (arm_evt)                   cnt_q <= '0;
        else if (take && (cnt_q == LAST))   cnt_q <= '0;
        else if (take)                      cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:   if (arm_evt) state_d = CAP_ARMED;
            CAP_ARMED:  if (vs_fall && !field) state_d = CAP_ACTIVE;
            CAP_ACTIVE: begin
                if (arm_evt)                        state_d = CAP_ARMED;
                else if (take && (cnt_q == LAST))   state_d = CAP_DONE;
            end
            CAP_DONE:   if (arm_evt) state_d = CAP_ARMED;
        endcase
    end

    always_comb begin
        we_n     = !take;
        done_evt = take && (cnt_q == LAST);
    end
endmodule

// File: rtl/vfc_capture_ctrl.sv
module vfc_capture_ctrl
    import vfc_pkg::*;
#(
    parameter int PIXEL_TARGET = 45000,
    parameter int SYNC_STAGES  = 2,
    parameter int RST_CYCLES   = 2,
    parameter int IRQ_CYCLES   = 4
) (
    input  logic             wr_clk,
    input  logic             rst_n,
    input  logic             vid_vsync,
    input  logic             vid_vblank,
    input  logic             vid_active,
    input  logic             vid_field,
    input  logic [CMD_W-1:0] host_cmd,
    input  logic             host_cs_n,
    input  logic             host_oe_n,
    input  logic             host_rd_n,
    output logic             buf_we_n,
    output logic             buf_wrst_n,
    output logic             buf_rrst_n,
    output logic             buf_oe_n,
    output logic             buf_re_n,
    output logic             host_irq_n
);
    logic wrst_evt, rrst_evt, arm_evt, done_evt;

    vfc_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(wr_clk), .rst_n(rst_n), .cmd_async(host_cmd),
        .wrst_evt(wrst_evt), .rrst_evt(rrst_evt), .arm_evt(arm_evt)
    );

    vfc_capture_fsm #(.PIXEL_TARGET(PIXEL_TARGET)) u_fsm (
        .clk(wr_clk), .rst_n(rst_n), .arm_evt(arm_evt),
        .vsync(vid_vsync), .vblank(vid_vblank), .active(vid_active),
        .field(vid_field), .we_n(buf_we_n), .done_evt(done_evt)
    );

    vfc_pulse #(.LEN(RST_CYCLES)) u_wrst (
        .clk(wr_clk), .rst_n(rst_n), .trig(wrst_evt), .pulse_n(buf_wrst_n)
    );

    vfc_pulse #(.LEN(RST_CYCLES)) u_rrst (
        .clk(wr_clk), .rst_n(rst_n), .trig(rrst_evt), .pulse_n(buf_rrst_n)
    );

    vfc_pulse #(.LEN(IRQ_CYCLES)) u_irq (
        .clk(wr_clk), .rst_n(rst_n), .trig(done_evt), .pulse_n(host_irq_n)
    );

    assign buf_oe_n = host_cs_n | host_oe_n;
    assign buf_re_n = host_cs_n | host_oe_n | host_rd_n;
endmodule

// File: rtl/vfc_capture_ctrl_chk.sv
module vfc_capture_ctrl_chk (
    input logic wr_clk,
    input logic rst_n,
    input logic vid_vblank,
    input logic vid_active,
    input logic vid_field,
    input logic buf_we_n,
    input logic buf_wrst_n,
    input logic buf_rrst_n,
    input logic buf_oe_n,
    input logic buf_re_n,
    input logic host_irq_n
);
    p_we_qual_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !buf_we_n |-> (!vid_vblank && vid_active));

    p_odd_only_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !buf_we_n |-> !vid_field);

    p_irq_hold_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(host_irq_n) |=> !host_irq_n);

    p_read_nest_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !buf_re_n |-> !buf_oe_n);

    p_wrst_hold_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(buf_wrst_n) |=> !buf_wrst_n);

    p_rrst_hold_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(buf_rrst_n) |=> !buf_rrst_n);
endmodule

bind vfc_capture_ctrl vfc_capture_ctrl_chk u_chk (
    .wr_clk(wr_clk), .rst_n(rst_n), .vid_vblank(vid_vblank),
    .vid_active(vid_active), .vid_field(vid_field), .buf_we_n(buf_we_n),
    .buf_wrst_n(buf_wrst_n), .buf_rrst_n(buf_rrst_n), .buf_oe_n(buf_oe_n),
    .buf_re_n(buf_re_n), .host_irq_n(host_irq_n)
);

// File: tb/vfc_capture_ctrl_tb.sv
module vfc_capture_ctrl_tb_top;
    localparam int TGT = 6;
    localparam int IRQ = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic vsync = 1'b1, vblank = 1'b1, vact = 1'b0, vfld = 1'b1;
    logic [2:0] cmd = 3'b000;
    logic cs_n = 1'b1, oe_n = 1'b1, rd_n = 1'b1;
    logic we_n, wrst_n, rrst_n, boe_n, bre_n, irq_n;

    int n_run = 0, n_fail = 0;
    bit m_armed = 0, m_active = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    vfc_capture_ctrl #(.PIXEL_TARGET(TGT), .IRQ_CYCLES(IRQ)) dut_i (
        .wr_clk(clk), .rst_n(rst_n), .vid_vsync(vsync), .vid_vblank(vblank),
        .vid_active(vact), .vid_field(vfld), .host_cmd(cmd),
        .host_cs_n(cs_n), .host_oe_n(oe_n), .host_rd_n(rd_n),
        .buf_we_n(we_n), .buf_wrst_n(wrst_n), .buf_rrst_n(rrst_n),
        .buf_oe_n(boe_n), .buf_re_n(bre_n), .host_irq_n(irq_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Hold a command for 8 cycles; only one pulse may appear (R7, R8, R9).
    task automatic send_cmd(input logic [2:0] c);
        cmd = c;
        for (int k = 1; k <= 8; k++) begin
            step();
            chk("R7 wrst", wrst_n, !(c == 3'b001 && (k == 3 || k == 4)));
            chk("R8 rrst", rrst_n, !(c == 3'b010 && (k == 3 || k == 4)));
        end
        if (c == 3'b100) begin
            m_armed = 1; m_active = 0; m_cnt = 0;
        end
        cmd = 3'b000;
        repeat (3) step();
    endtask

    task automatic vsfall(input logic f);
        vblank = 1; vact = 0;
        vsync = 0; step();
        vsync = 1; vfld = f; step();
        vsync = 0; step();
        vfld = 1; step();
        if (m_armed && !f) begin
            m_armed = 0; m_active = 1;
        end
    endtask

    task automatic pix(input logic vb, input logic av, input logic f);
        bit ok;
        vblank = vb; vact = av; vfld = f;
        #1;
        ok = m_active && !vb && av && !f;
        chk("R2 R3 R4 write enable", we_n, !ok);
        if (ok) m_cnt++;
        step();
        if (m_cnt == TGT) begin
            m_cnt = 0; m_active = 0;
            vblank = 0; vact = 1; vfld = 0;
            for (int k = 1; k <= IRQ + 1; k++) begin
                #1;
                chk("R5 irq", irq_n, (k == IRQ + 1));
                chk("R4 no write after done", we_n, 1);
                step();
            end
            vblank = 1; vact = 0;
        end else begin
            chk("R5 irq idle", irq_n, 1);
        end
    endtask

    task automatic sweep();
        for (int i = 0; i < 8; i++) pix(i[2], i[1], i[0]);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R4 reset we", we_n, 1);
        chk("R7 reset wrst", wrst_n, 1);
        chk("R8 reset rrst", rrst_n, 1);
        chk("R5 reset irq", irq_n, 1);

        for (int i = 0; i < 8; i++) begin
            cs_n = i[2]; oe_n = i[1]; rd_n = i[0];
            #1;
            chk("R6 oe", boe_n, i[2] | i[1]);
            chk("R6 re", bre_n, i[2] | i[1] | i[0]);
            step();
        end
        cs_n = 1; oe_n = 1; rd_n = 1;

        for (int c = 0; c < 8; c++) if (c != 4) send_cmd(3'(c));
        vsfall(0);
        sweep();                               // R9/R4: undefined codes did not arm

        send_cmd(3'b100);                      // R10
        vsync = 0; step(); vsync = 1; step(); // rising edge only: R1
        sweep();
        vsfall(1);                             // fall in even field: R1
        sweep();
        vsfall(0);                             // R1 start
        sweep();                               // one pixel accepted
        repeat (TGT - 1) pix(0, 1, 0);         // completes: R5
        sweep();                               // R4 done state

        send_cmd(3'b100);                      // R10 rearm from done
        sweep();
        vsfall(0);
        for (int i = 0; i < TGT; i++) begin
            pix(1, 1, 0);
            pix(0, 1, 0);
        end

        send_cmd(3'b100);                      // R11 abandon mid-capture
        vsfall(0);
        repeat (3) pix(0, 1, 0);
        send_cmd(3'b100);
        sweep();
        vsfall(0);
        repeat (TGT) pix(0, 1, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule